// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address for each beat of a four-beat burst. When a new command is accepted it captures a full starting address. The upper bits are held for the whole burst, and the two lowest bits set where the burst begins. On each later advance cycle it moves one beat forward. Beats follow either a wrapping linear order or an XOR-based interleaved order, chosen by a mode pin that is normally tied to a fixed level.

An active-low clock enable freezes all of the block's state, so a stalled pipeline keeps its current address. The output is the held upper bits joined to the 2-bit beat offset, and it is valid in the cycle after the load or advance edge. A synchronous active-high reset clears the state.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, all state is cleared and `addr_out` reads zero after that edge.
- R2: With `ce_n` low and `adv_ld` low at an edge, `addr_out` equals the `addr_in` value sampled at that edge.
- R3: With `mode_ilv` low (linear order), after n advance edges since the last load the low two bits of `addr_out` equal (start + n) mod 4. Here start is bits [1:0] of the loaded address; a start of 2 gives 2, 3, 0, 1.
- R4: With `mode_ilv` high (interleaved order), after n advance edges the low two bits equal start XOR n; a start of 1 gives 1, 0, 3, 2.
- R5: Advance edges never alter `addr_out[ADDR_W-1:2]`. After the fourth beat the offset wraps back to the start value, and the upper bits are unchanged.
- R6: With `ce_n` high at an edge, `addr_out` keeps its value whatever `adv_ld` and `addr_in` carry.
- R7: Reset takes priority over the hold: `rst` high clears the state even while `ce_n` is high.
- R8: A load in the middle of a burst discards the old burst. The next beats start from the new address at beat zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Clock enable, active low; high holds all state |
| adv_ld | input | 1 | 0 = load `addr_in`, 1 = advance one beat |
| mode_ilv | input | 1 | 0 = linear wrap order, 1 = interleaved XOR order |
| addr_in | input | ADDR_W | Starting address captured on a load |
| addr_out | output | ADDR_W | Current beat address: held upper bits plus offset |

## Verification
Two pairs of controls can arrive in the same cycle and contend. The first is a load request together with an inactive clock enable. The bench drives `adv_ld` low with a fresh `addr_in` while `ce_n` is high, and requires the previous address to persist. The second is a reset together with a hold: reset must win, and `addr_out` must read zero. A load issued mid-burst is also covered, and the bench checks that the beat count restarts from zero. A behavioural model is compared with `addr_out` on every clock, in both orders and from every start offset, including wraps at the top of the address range.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int OFS_W = 2;

    typedef logic [OFS_W-1:0] ofs_t;

    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } order_e;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_STEP  = 2'd2,
        OP_CLEAR = 2'd3
    } op_e;

    typedef struct packed {
        ofs_t start;
        ofs_t beat;
    } beat_state_t;

    function automatic op_e decode_op(logic rst, logic ce_n, logic adv_ld);
        if (rst)         return OP_CLEAR;
        else if (ce_n)   return OP_HOLD;
        else if (!adv_ld) return OP_LOAD;
        else             return OP_STEP;
    endfunction

    function automatic ofs_t beat_offset(order_e ord, ofs_t start, ofs_t beat);
        if (ord == ORD_XOR) return start ^ beat;
        else                return ofs_t'(start + beat);
    endfunction

endpackage

// File: rtl/burst_base_reg.sv
module burst_base_reg
    import burst_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  op_e               op,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] base_q
);
    always_ff @(posedge clk) begin
        case (op)
            OP_CLEAR: base_q <= '0;
            OP_LOAD:  base_q <= addr_in;
            default:  base_q <= base_q;
        endcase
    end

    p_base_frozen_r5: assert property (@(posedge clk) disable iff (op == OP_CLEAR)
        (op == OP_STEP || op == OP_HOLD) |=> $stable(base_q));
endmodule

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt
    import burst_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  op_e  op,
    output ofs_t beat_q
);
    always_ff @(posedge clk) begin
        case (op)
            OP_CLEAR, OP_LOAD: beat_q <= '0;
            OP_STEP:           beat_q <= ofs_t'(beat_q + 1'b1);
            default:           beat_q <= beat_q;
        endcase
    end

    p_step_one_r3: assert property (@(posedge clk) disable iff (rst)
        (op == OP_STEP) |=> beat_q == ofs_t'($past(beat_q) + 1'b1));
    p_hold_beat_r6: assert property (@(posedge clk) disable iff (rst)
        (op == OP_HOLD) |=> $stable(beat_q));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_pkg::*;
(
    input  order_e ord,
    input  ofs_t   start,
    input  ofs_t   beat,
    output ofs_t   offset
);
    assign offset = beat_offset(ord, start, beat);
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              adv_ld,
    input  logic              mode_ilv,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int UPPER_W = ADDR_W - OFS_W;

    op_e               op;
    logic [ADDR_W-1:0] base_q;
    beat_state_t       bstate;
    ofs_t              offset;
    order_e            ord;

    assign op  = decode_op(rst, ce_n, adv_ld);
    assign ord = order_e'(mode_ilv);

    burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk    (clk),
        .op     (op),
        .addr_in(addr_in),
        .base_q (base_q)
    );

    burst_beat_cnt u_cnt (
        .clk   (clk),
        .rst   (rst),
        .op    (op),
        .beat_q(bstate.beat)
    );

    assign bstate.start = base_q[OFS_W-1:0];

    burst_order_map u_map (
        .ord   (ord),
        .start (bstate.start),
        .beat  (bstate.beat),
        .offset(offset)
    );

    assign addr_out = {base_q[ADDR_W-1:OFS_W], offset};

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && !adv_ld) |=> addr_out == $past(addr_in));
    p_upper_kept_r5: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && adv_ld) |=> addr_out[ADDR_W-1:OFS_W] == $past(addr_out[ADDR_W-1:OFS_W]));
    p_hold_out_r6: assert property (@(posedge clk) disable iff (rst)
        (ce_n && $stable(mode_ilv)) |=> addr_out == $past(addr_out));

    if (UPPER_W < 1) begin : g_bad_width
        initial $error("ADDR_W must exceed the offset width");
    end
endmodule

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce_n = 1'b0;
    logic          adv_ld = 1'b0;
    logic          mode_ilv = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;

    int n_run = 0;
    int n_fail = 0;

    int m_base = 0;
    int m_start = 0;
    int m_beat = 0;

    always #2.5 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .adv_ld(adv_ld),
        .mode_ilv(mode_ilv), .addr_in(addr_in), .addr_out(addr_out)
    );

    task automatic step(input logic r, input logic cen, input logic adv,
                        input logic ilv, input int a, input string req);
        int off;
        int expv;
        rst = r; ce_n = cen; adv_ld = adv; mode_ilv = ilv; addr_in = AW'(a);
        @(posedge clk);
        if (r) begin
            m_base = 0; m_start = 0; m_beat = 0;
        end else if (!cen) begin
            if (!adv) begin
                m_base = a >> 2; m_start = a & 3; m_beat = 0;
            end else begin
                m_beat = (m_beat + 1) % 4;
            end
        end
        #2;
        off  = ilv ? (m_start ^ m_beat) : ((m_start + m_beat) % 4);
        expv = (m_base << 2) | off;
        n_run++;
        if (addr_out !== AW'(expv)) begin
            n_fail++;
            $display("FAIL %s: addr_out=%h expected=%h", req, addr_out, AW'(expv));
        end
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        step(1, 0, 0, 0, 'h2AAAA, "R1");
        step(1, 0, 1, 0, 'h11111, "R1");
        // linear from start 2 with a wrap past beat four
        step(0, 0, 0, 0, 'h1235A, "R2");
        for (int i = 0; i < 5; i++) step(0, 0, 1, 0, 'h0, "R3");
        // interleaved from every start offset
        for (int s = 0; s < 4; s++) begin
            step(0, 0, 0, 1, 'h0ABC4 | s, "R2");
            for (int i = 0; i < 5; i++) step(0, 0, 1, 1, 'h3FFFF, "R4");
        end
        // linear from every start at the top of the range
        for (int s = 0; s < 4; s++) begin
            step(0, 0, 0, 0, 'h3FFFC | s, "R2");
            for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 'h0, "R5");
        end
        // hold contends with load, then with advance
        step(0, 0, 0, 0, 'h00105, "R2");
        step(0, 0, 1, 0, 'h0, "R3");
        step(0, 1, 0, 0, 'h3F0F0, "R6");
        step(0, 1, 1, 0, 'h12345, "R6");
        step(0, 1, 0, 0, 'h00000, "R6");
        step(0, 0, 1, 0, 'h0, "R3");
        // load mid-burst restarts at beat zero
        step(0, 0, 0, 1, 'h20003, "R8");
        step(0, 0, 1, 1, 'h0, "R8");
        step(0, 0, 0, 1, 'h1FFF1, "R8");
        step(0, 0, 1, 1, 'h0, "R8");
        step(0, 0, 1, 1, 'h0, "R4");
        // reset wins over hold
        step(1, 1, 1, 1, 'h15555, "R7");
        step(0, 1, 0, 0, 'h2AAAA, "R7");
        step(0, 0, 1, 0, 'h0, "R5");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule